// File: doc/BRIEF.md
# DDR2 Write Burst Sequencer

This block sits on the controller side of a DDR2-style memory channel. It carries out one complete write transaction. It accepts a request that holds a bank, a row, a column and up to eight data beats. It opens the row with an activate command and issues the write command. After the write latency it places the data on the bus at double rate, with the strobe framed by a preamble and a postamble. Once the write-recovery window has passed it closes the bank with a precharge. The next request is held off until the precharge-to-activate time has elapsed.

Double-rate signalling is modelled per core clock cycle as two half-cycle slots: one after the rising edge and one after the falling edge. Each slot has its own data value, strobe value and output-enable. One output-enable pair serves both the data and the strobe lines. All latencies are run-time configuration inputs. They are sampled together with the request, so one transaction runs with one consistent set of timings.

Cycle numbering below counts from the activate cycle (cycle 0). T0 is the write-command cycle, WL is the write latency and E is the last burst cycle.

Top module: `ddr2_wr_seq`

## Requirements
- R1: After reset and on every cycle that carries no other command, the command pins show NOP (chip-select, row-strobe, column-strobe, write-enable = 0,1,1,1). On those cycles bank and address are zero. `req_ready` is high out of reset and both output-enables are low.
- R2: The cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), the pins show activate (0,0,1,1) with the request's bank and its row on the address. `req_ready` stays low from then until the transaction has finished.
- R3: The write command (0,1,0,0) appears max(`cfg_trcd`,1) cycles after activate, at cycle T0. It carries the bank and the column in the low address bits. Address bit 10 is low, so there is no auto-precharge.
- R4: The write latency WL is `cfg_al` + `cfg_cl` − 1, with a floor of 2. In cycle T0+WL−1 (the preamble) both output-enable slots are high, both strobe slots are low and the data lines are zero.
- R5: The burst covers BL/2 cycles starting at T0+WL. BL is 8 when `cfg_bl8` is 1 and 4 otherwise. In burst cycle j the rising slot carries beat 2j and the falling slot carries beat 2j+1. Beat k is `req_data[k*8 +: 8]`. The strobe is 1 in the rising slot and 0 in the falling slot, and both enables are high.
- R6: Precharge (0,0,1,0) to the same bank, with address bit 10 low, appears at cycle E+1+max(`cfg_twr`,1), where E is the last burst cycle.
- R7: The cycle after the burst is a postamble. The rising-slot enable is high with the strobe low, and the falling-slot enable is low. On every cycle outside the preamble, burst and postamble, both enables are low and all data and strobe outputs are zero.
- R8: After a precharge at cycle P, `req_ready` rises again at cycle P+max(`cfg_trp`,2)−1. A request that is already waiting therefore gets its activate exactly max(`cfg_trp`,2) cycles after the precharge.
- R9: Configuration, address and data inputs are captured when the request is accepted. Changing them during the transaction has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column (at most 10 bits) |
| req_data | input | 8*DQ_W | Eight data beats, beat k in bits k*DQ_W upward |
| cfg_al | input | CFG_W | Additive latency |
| cfg_cl | input | CFG_W | CAS latency |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_twr | input | TIM_W | Write-recovery cycles |
| cfg_trp | input | TIM_W | Precharge-to-activate cycles |
| cfg_trcd | input | TIM_W | Activate-to-write cycles |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | max(ROW_W,11) | Row, column or precharge address |
| dq_rise | output | DQ_W | Data in the rising-edge slot |
| dq_fall | output | DQ_W | Data in the falling-edge slot |
| dqs_rise | output | 1 | Strobe value in the rising-edge slot |
| dqs_fall | output | 1 | Strobe value in the falling-edge slot |
| io_oe_rise | output | 1 | Data/strobe drive enable, rising-edge slot |
| io_oe_fall | output | 1 | Data/strobe drive enable, falling-edge slot |

## Verification
The hardest situation to reach from the ports is a request that is already pending when the precharge-to-activate window closes. This must hold with clamped timing values (zero write recovery, zero activate-to-write time, a precharge time of 1, a CAS latency low enough to hit the write-latency floor), and with the configuration inputs changing in the middle of the burst. The stimulus sweeps every combination of a small range of each timing. It keeps the next request driven from the exact cycle the previous one ends, and scrambles configuration, address and data right after each acceptance. This places every activate on the earliest legal cycle while stale inputs sit on the ports.

// File: rtl/ddr2_wr_pkg.sv
package ddr2_wr_pkg;

  localparam int MAX_BEATS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_WR, ST_WLAT, ST_BURST, ST_REC, ST_PRE
  } seq_state_e;

  typedef enum logic [1:0] {OP_NOP, OP_ACT, OP_WRITE, OP_PRE} mem_op_e;

  typedef enum logic [1:0] {PH_IDLE, PH_PREAMBLE, PH_BURST, PH_POSTAMBLE} dq_phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t op_pins(input mem_op_e op);
    cmd_pins_t p;
    case (op)
      OP_ACT:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
      OP_WRITE: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
      OP_PRE:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr2_wr_fsm.sv
module ddr2_wr_fsm
  import ddr2_wr_pkg::*;
#(
  parameter int CFG_W = 3,
  parameter int TIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic             cfg_bl8,
  input  logic [TIM_W-1:0] cfg_twr,
  input  logic [TIM_W-1:0] cfg_trp,
  input  logic [TIM_W-1:0] cfg_trcd,
  output logic             capture,
  output mem_op_e          op,
  output dq_phase_e        phase,
  output logic [1:0]       beat_idx
);

  localparam int CNT_W = (CFG_W + 1 > TIM_W) ? CFG_W + 1 : TIM_W;
  localparam logic [CFG_W:0] LAT_FLOOR = (CFG_W + 1)'(3);

  seq_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [TIM_W-1:0] gap_q, gap_n;
  logic [1:0]       bidx_q, bidx_n;

  logic [CFG_W-1:0] al_q, cl_q;
  logic             bl8_q;
  logic [TIM_W-1:0] twr_q, trp_q, trcd_q;

  logic [CFG_W:0]   lat_sum;
  logic [CNT_W-1:0] wl_eff;
  logic [TIM_W-1:0] trcd_eff, twr_eff, trp_eff;
  logic [1:0]       last_idx;

  // Effective timings from the captured configuration, with floors applied
  always_comb begin
    lat_sum  = {1'b0, al_q} + {1'b0, cl_q};
    wl_eff   = (lat_sum < LAT_FLOOR) ? CNT_W'(2) : CNT_W'(lat_sum) - CNT_W'(1);
    trcd_eff = (trcd_q == '0) ? TIM_W'(1) : trcd_q;
    twr_eff  = (twr_q == '0) ? TIM_W'(1) : twr_q;
    trp_eff  = (trp_q < TIM_W'(2)) ? TIM_W'(2) : trp_q;
    last_idx = bl8_q ? 2'd3 : 2'd1;
  end

  assign req_ready = (state_q == ST_IDLE) && (gap_q == '0);
  assign capture   = req_valid && req_ready;

  // Next-state process
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    gap_n   = gap_q;
    bidx_n  = bidx_q;
    case (state_q)
      ST_IDLE: begin
        if (gap_q != '0) gap_n = gap_q - TIM_W'(1);
        if (capture) state_n = ST_ACT;
      end
      ST_ACT: begin
        if (trcd_eff == TIM_W'(1)) begin
          state_n = ST_WR;
        end else begin
          state_n = ST_RCD;
          cnt_n   = CNT_W'(trcd_eff) - CNT_W'(2);
        end
      end
      ST_RCD: begin
        if (cnt_q == '0) state_n = ST_WR;
        else             cnt_n   = cnt_q - CNT_W'(1);
      end
      ST_WR: begin
        state_n = ST_WLAT;
        cnt_n   = wl_eff - CNT_W'(2);
      end
      ST_WLAT: begin
        if (cnt_q == '0) begin
          state_n = ST_BURST;
          bidx_n  = 2'd0;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      ST_BURST: begin
        if (bidx_q == last_idx) begin
          state_n = ST_REC;
          cnt_n   = CNT_W'(twr_eff) - CNT_W'(1);
        end else begin
          bidx_n = bidx_q + 2'd1;
        end
      end
      ST_REC: begin
        if (cnt_q == '0) state_n = ST_PRE;
        else             cnt_n   = cnt_q - CNT_W'(1);
      end
      ST_PRE: begin
        state_n = ST_IDLE;
        gap_n   = trp_eff - TIM_W'(2);
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      bidx_q  <= '0;
      al_q    <= '0;
      cl_q    <= '0;
      bl8_q   <= 1'b0;
      twr_q   <= '0;
      trp_q   <= '0;
      trcd_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      gap_q   <= gap_n;
      bidx_q  <= bidx_n;
      if (capture) begin
        al_q   <= cfg_al;
        cl_q   <= cfg_cl;
        bl8_q  <= cfg_bl8;
        twr_q  <= cfg_twr;
        trp_q  <= cfg_trp;
        trcd_q <= cfg_trcd;
      end
    end
  end

  // Decoded outputs
  always_comb begin
    case (state_q)
      ST_ACT:  op = OP_ACT;
      ST_WR:   op = OP_WRITE;
      ST_PRE:  op = OP_PRE;
      default: op = OP_NOP;
    endcase
    if (state_q == ST_WLAT && cnt_q == '0)
      phase = PH_PREAMBLE;
    else if (state_q == ST_BURST)
      phase = PH_BURST;
    else if (state_q == ST_REC && cnt_q == CNT_W'(twr_eff) - CNT_W'(1))
      phase = PH_POSTAMBLE;
    else
      phase = PH_IDLE;
  end

  assign beat_idx = bidx_q;

endmodule

// File: rtl/ddr2_wr_cmd_enc.sv
module ddr2_wr_cmd_enc
  import ddr2_wr_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13,
  parameter int COL_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [BA_W-1:0]               req_bank,
  input  logic [ROW_W-1:0]              req_row,
  input  logic [COL_W-1:0]              req_col,
  input  mem_op_e                       op,
  output logic                          mem_cs_n,
  output logic                          mem_ras_n,
  output logic                          mem_cas_n,
  output logic                          mem_we_n,
  output logic [BA_W-1:0]               mem_ba,
  output logic [((ROW_W > 11) ? ROW_W : 11)-1:0] mem_addr
);

  localparam int ADDR_W = (ROW_W > 11) ? ROW_W : 11;

  logic [BA_W-1:0]  bank_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  cmd_pins_t        pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (capture) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
    end
  end

  // Column occupies the low bits; bit 10 (auto-precharge / all-banks) stays low
  always_comb begin
    pins = op_pins(op);
    case (op)
      OP_ACT: begin
        mem_ba   = bank_q;
        mem_addr = ADDR_W'(row_q);
      end
      OP_WRITE: begin
        mem_ba   = bank_q;
        mem_addr = ADDR_W'(col_q);
      end
      OP_PRE: begin
        mem_ba   = bank_q;
        mem_addr = '0;
      end
      default: begin
        mem_ba   = '0;
        mem_addr = '0;
      end
    endcase
  end

  assign mem_cs_n  = pins.cs_n;
  assign mem_ras_n = pins.ras_n;
  assign mem_cas_n = pins.cas_n;
  assign mem_we_n  = pins.we_n;

endmodule

// File: rtl/ddr2_wr_dq_path.sv
module ddr2_wr_dq_path
  import ddr2_wr_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture,
  input  logic [MAX_BEATS*DQ_W-1:0] req_data,
  input  dq_phase_e                 phase,
  input  logic [1:0]                beat_idx,
  output logic [DQ_W-1:0]           dq_rise,
  output logic [DQ_W-1:0]           dq_fall,
  output logic                      dqs_rise,
  output logic                      dqs_fall,
  output logic                      io_oe_rise,
  output logic                      io_oe_fall
);

  localparam int BUF_W = MAX_BEATS * DQ_W;

  logic [BUF_W-1:0] buf_q;
  logic [DQ_W-1:0]  beat [MAX_BEATS];
  logic [2:0]       sel_r, sel_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_q <= '0;
    else if (capture) buf_q <= req_data;
  end

  for (genvar k = 0; k < MAX_BEATS; k++) begin : g_beat
    assign beat[k] = buf_q[k*DQ_W +: DQ_W];
  end

  assign sel_r = {beat_idx, 1'b0};
  assign sel_f = {beat_idx, 1'b1};

  always_comb begin
    dq_rise    = '0;
    dq_fall    = '0;
    dqs_rise   = 1'b0;
    dqs_fall   = 1'b0;
    io_oe_rise = 1'b0;
    io_oe_fall = 1'b0;
    case (phase)
      PH_PREAMBLE: begin
        io_oe_rise = 1'b1;
        io_oe_fall = 1'b1;
      end
      PH_BURST: begin
        io_oe_rise = 1'b1;
        io_oe_fall = 1'b1;
        dqs_rise   = 1'b1;
        dq_rise    = beat[sel_r];
        dq_fall    = beat[sel_f];
      end
      PH_POSTAMBLE: io_oe_rise = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_wr_seq.sv
module ddr2_wr_seq
  import ddr2_wr_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int DQ_W  = 8,
  parameter int CFG_W = 3,
  parameter int TIM_W = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [BA_W-1:0]                        req_bank,
  input  logic [ROW_W-1:0]                       req_row,
  input  logic [COL_W-1:0]                       req_col,
  input  logic [8*DQ_W-1:0]                      req_data,
  input  logic [CFG_W-1:0]                       cfg_al,
  input  logic [CFG_W-1:0]                       cfg_cl,
  input  logic                                   cfg_bl8,
  input  logic [TIM_W-1:0]                       cfg_twr,
  input  logic [TIM_W-1:0]                       cfg_trp,
  input  logic [TIM_W-1:0]                       cfg_trcd,
  output logic                                   mem_cs_n,
  output logic                                   mem_ras_n,
  output logic                                   mem_cas_n,
  output logic                                   mem_we_n,
  output logic [BA_W-1:0]                        mem_ba,
  output logic [((ROW_W > 11) ? ROW_W : 11)-1:0] mem_addr,
  output logic [DQ_W-1:0]                        dq_rise,
  output logic [DQ_W-1:0]                        dq_fall,
  output logic                                   dqs_rise,
  output logic                                   dqs_fall,
  output logic                                   io_oe_rise,
  output logic                                   io_oe_fall
);

  logic      capture;
  mem_op_e   op;
  dq_phase_e phase;
  logic [1:0] beat_idx;

  ddr2_wr_fsm #(
    .CFG_W(CFG_W),
    .TIM_W(TIM_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cfg_al    (cfg_al),
    .cfg_cl    (cfg_cl),
    .cfg_bl8   (cfg_bl8),
    .cfg_twr   (cfg_twr),
    .cfg_trp   (cfg_trp),
    .cfg_trcd  (cfg_trcd),
    .capture   (capture),
    .op        (op),
    .phase     (phase),
    .beat_idx  (beat_idx)
  );

  ddr2_wr_cmd_enc #(
    .BA_W (BA_W),
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .req_bank (req_bank),
    .req_row  (req_row),
    .req_col  (req_col),
    .op       (op),
    .mem_cs_n (mem_cs_n),
    .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n),
    .mem_we_n (mem_we_n),
    .mem_ba   (mem_ba),
    .mem_addr (mem_addr)
  );

  ddr2_wr_dq_path #(
    .DQ_W(DQ_W)
  ) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .req_data  (req_data),
    .phase     (phase),
    .beat_idx  (beat_idx),
    .dq_rise   (dq_rise),
    .dq_fall   (dq_fall),
    .dqs_rise  (dqs_rise),
    .dqs_fall  (dqs_fall),
    .io_oe_rise(io_oe_rise),
    .io_oe_fall(io_oe_fall)
  );

endmodule

// File: rtl/ddr2_wr_seq_chk.sv
module ddr2_wr_seq_chk #(
  parameter int TIM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TIM_W-1:0] cfg_twr,
  input logic [TIM_W-1:0] cfg_trp,
  input logic             mem_cs_n,
  input logic             mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_we_n,
  input logic             dqs_rise,
  input logic             dqs_fall,
  input logic             io_oe_rise,
  input logic             io_oe_fall
);

  logic [2:0]       rcw;
  logic             is_act, is_pre;
  logic [TIM_W-1:0] twr_cap, trp_cap, trp_gap;
  logic [7:0]       since_pre, since_beat;
  logic [7:0]       twr_need, trp_need;

  assign rcw    = {mem_ras_n, mem_cas_n, mem_we_n};
  assign is_act = !mem_cs_n && rcw == 3'b011;
  assign is_pre = !mem_cs_n && rcw == 3'b010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twr_cap    <= '0;
      trp_cap    <= '0;
      trp_gap    <= '0;
      since_pre  <= 8'hFF;
      since_beat <= 8'hFF;
    end else begin
      if (req_valid && req_ready) begin
        twr_cap <= cfg_twr;
        trp_cap <= cfg_trp;
      end
      if (is_pre) trp_gap <= trp_cap;
      if (is_pre)                  since_pre <= 8'd1;
      else if (since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
      if (dqs_rise)                 since_beat <= 8'd1;
      else if (since_beat != 8'hFF) since_beat <= since_beat + 8'd1;
    end
  end

  assign twr_need = (twr_cap == '0) ? 8'd2 : 8'(twr_cap) + 8'd1;
  assign trp_need = (trp_gap < TIM_W'(2)) ? 8'd2 : 8'(trp_gap);

  // R1
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n && (rcw == 3'b111 || rcw == 3'b011 || rcw == 3'b100 || rcw == 3'b010));

  // R2
  act_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (is_act && !req_ready));

  // R6
  pre_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_beat == twr_need));

  // R8
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= trp_need));

  // R4
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_rise) |-> $past(io_oe_rise && io_oe_fall && !dqs_rise && !dqs_fall));

  // R5
  strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_rise |-> (io_oe_rise && io_oe_fall && !dqs_fall));

  // R7
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_rise) |-> (io_oe_rise && !io_oe_fall && !dqs_fall));

endmodule

bind ddr2_wr_seq ddr2_wr_seq_chk #(.TIM_W(TIM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cfg_twr   (cfg_twr),
  .cfg_trp   (cfg_trp),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .dqs_rise  (dqs_rise),
  .dqs_fall  (dqs_fall),
  .io_oe_rise(io_oe_rise),
  .io_oe_fall(io_oe_fall)
);

// File: tb/ddr2_wr_seq_bench.sv
module ddr2_wr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BA_W  = 2;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int DQ_W  = 8;
  localparam int CFG_W = 3;
  localparam int TIM_W = 4;
  localparam int ADDR_W = 13;

  logic              clk, rst_n, req_valid, req_ready;
  logic [BA_W-1:0]   req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic [8*DQ_W-1:0] req_data;
  logic [CFG_W-1:0]  cfg_al, cfg_cl;
  logic              cfg_bl8;
  logic [TIM_W-1:0]  cfg_twr, cfg_trp, cfg_trcd;
  logic              mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [BA_W-1:0]   mem_ba;
  logic [ADDR_W-1:0] mem_addr;
  logic [DQ_W-1:0]   dq_rise, dq_fall;
  logic              dqs_rise, dqs_fall, io_oe_rise, io_oe_fall;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  ddr2_wr_seq u_ddr2_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8), .cfg_twr(cfg_twr),
    .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dqs_rise(dqs_rise), .dqs_fall(dqs_fall), .io_oe_rise(io_oe_rise), .io_oe_fall(io_oe_fall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input string tag, input int cyc, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, got, exp);
    end
  endtask

  function automatic logic [63:0] obs_cmd();
    return {44'b0, req_ready, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr};
  endfunction

  function automatic logic [63:0] obs_dq();
    return {44'b0, io_oe_rise, io_oe_fall, dqs_rise, dqs_fall, dq_rise, dq_fall};
  endfunction

  function automatic logic [63:0] mk_cmd(logic rdy, logic [3:0] pins, logic [1:0] ba, logic [12:0] addr);
    return {44'b0, rdy, pins, ba, addr};
  endfunction

  function automatic logic [63:0] mk_dq(logic [3:0] ctl, logic [7:0] r, logic [7:0] f);
    return {44'b0, ctl, r, f};
  endfunction

  function automatic logic [7:0] pat(int run, int k);
    return 8'((run * 13 + k * 29 + 7) ^ 165);
  endfunction

  task automatic run_one(input int run, input int al, input int cl, input int bl8,
                         input int twr, input int trp, input int trcd);
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic [63:0] data;
    int tr, wl, nb, t0, pre_c, b0, post_c, tw, pc, trpe;
    bank = 2'(run);
    row  = 13'(run * 97 + 5);
    col  = 10'(run * 31 + 3);
    for (int k = 0; k < 8; k++) data[k*8 +: 8] = pat(run, k);
    req_bank = bank; req_row = row; req_col = col; req_data = data;
    cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8[0];
    cfg_twr = 4'(twr); cfg_trp = 4'(trp); cfg_trcd = 4'(trcd);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // scramble every captured input right after acceptance (R9)
    req_valid = 1'b0;
    req_bank = ~bank; req_row = ~row; req_col = ~col; req_data = ~data;
    cfg_al = 3'd7; cfg_cl = 3'd7; cfg_bl8 = ~bl8[0];
    cfg_twr = 4'd9; cfg_trp = 4'd11; cfg_trcd = 4'd6;
    tr     = (trcd == 0) ? 1 : trcd;
    t0     = tr;
    wl     = (al + cl < 3) ? 2 : al + cl - 1;
    nb     = bl8 ? 4 : 2;
    pre_c  = t0 + wl - 1;
    b0     = t0 + wl;
    post_c = b0 + nb;
    tw     = (twr == 0) ? 1 : twr;
    pc     = post_c + tw;
    trpe   = (trp < 2) ? 2 : trp;
    for (int c = 0; c <= pc; c++) begin
      logic [63:0] ec, ed;
      string tc, td;
      if (c == 0) begin
        ec = mk_cmd(1'b0, 4'b0011, bank, row);           tc = "R2/R9";
      end else if (c == t0) begin
        ec = mk_cmd(1'b0, 4'b0100, bank, 13'(col));      tc = "R3/R9";
      end else if (c == pc) begin
        ec = mk_cmd(1'b0, 4'b0010, bank, 13'd0);         tc = "R6";
      end else begin
        ec = mk_cmd(1'b0, 4'b0111, 2'd0, 13'd0);         tc = "R1";
      end
      if (c == pre_c) begin
        ed = mk_dq(4'b1100, 8'd0, 8'd0);                 td = "R4";
      end else if (c >= b0 && c < post_c) begin
        ed = mk_dq(4'b1110, pat(run, 2*(c-b0)), pat(run, 2*(c-b0)+1)); td = "R5/R9";
      end else if (c == post_c) begin
        ed = mk_dq(4'b1000, 8'd0, 8'd0);                 td = "R7";
      end else begin
        ed = mk_dq(4'b0000, 8'd0, 8'd0);                 td = "R7";
      end
      compare(tc, c, obs_cmd(), ec);
      compare(td, c, obs_dq(), ed);
      @(negedge clk);
    end
    for (int c = pc + 1; ; c++) begin
      compare("R8", c, {63'b0, req_ready}, {63'b0, (c == pc + trpe - 1)});
      if (c >= pc + trpe - 1) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int run;
    rst_n = 1'b0; req_valid = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; req_data = '0;
    cfg_al = '0; cfg_cl = 3'd3; cfg_bl8 = 1'b0; cfg_twr = 4'd1; cfg_trp = 4'd2; cfg_trcd = 4'd1;
    repeat (3) @(negedge clk);
    compare("R1", 0, obs_cmd(), mk_cmd(1'b1, 4'b0111, 2'd0, 13'd0));
    compare("R1", 0, obs_dq(), mk_dq(4'b0000, 8'd0, 8'd0));
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 1, obs_cmd(), mk_cmd(1'b1, 4'b0111, 2'd0, 13'd0));
    compare("R1", 1, obs_dq(), mk_dq(4'b0000, 8'd0, 8'd0));
    run = 0;
    for (int al = 0; al <= 2; al++)
      for (int cl = 2; cl <= 5; cl++)
        for (int bl8 = 0; bl8 <= 1; bl8++)
          for (int twr = 0; twr <= 2; twr++)
            for (int trp = 1; trp <= 3; trp++)
              for (int trcd = 0; trcd <= 2; trcd++) begin
                run_one(run, al, cl, bl8, twr, trp, trcd);
                run++;
              end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule